// File: doc/BRIEF.md
# MDIO Management Frame Master

This block drives the two-wire management bus that a MAC uses to reach the configuration registers of an Ethernet PHY. One request names a read or a write, a 5-bit PHY address, a 5-bit register number and, for writes, a 16-bit value. The block then runs one complete bus transaction on its own and reports the 16-bit result with a single-cycle done pulse.

The management clock is made from the system clock by a half-period divider, and each bit period is one low half followed by one high half. A transaction has four parts. First comes a preamble of idle ones. Next the frame bits are driven most significant bit first. On a read, the block then releases the data line for one turnaround period and captures 16 bits from the PHY. Last comes a closing pad of idle ones. The shared data line is modelled as a driven value, an output enable and a sampled input. The pad that closes a transaction is as long as the preamble that opens it.

Top module: `mgmt_frame_master`

## Requirements
- R1: While reset is high and in the first cycle after it, busy, done, mdc and mdo_oe are low, mdo is high and rdata is zero.
- R2: When req_valid is high and busy is low, the request is accepted at that clock edge. busy is high from the next cycle through the last cycle before done. In the done cycle busy is low, and a request presented in that cycle is accepted.
- R3: After acceptance there are PAD_LEN (default 32) bit periods with mdo_oe and mdo both high. Each bit period is HALF_DIV system cycles with mdc low followed by HALF_DIV cycles with mdc high, and mdc is low in the first cycle after acceptance.
- R4: The frame word is {2'b01, opcode, phy[4:0], reg[4:0], 2'b10, wdata[15:0]}. The opcode is 2'b10 for a read and 2'b01 for a write. Bits go out most significant bit first, one per bit period, starting right after the preamble.
- R5: mdo changes only at the start of a low half of mdc. It never changes while mdc is high.
- R6: A write drives all 32 frame bits with mdo_oe high.
- R7: A read drives only frame bits 31 down to 18. It then holds mdo_oe low for one turnaround period and for 16 sampling periods. In each sampling period, mdi is captured at the clock edge where mdc rises. The first captured bit becomes rdata[15].
- R8: Every transaction ends with PAD_LEN bit periods with mdo_oe and mdo high.
- R9: done is high for exactly one cycle, the cycle after the last closing bit period. From that cycle on, rdata holds the captured value for a read or the written value for a write, until the next done.
- R10: A request presented while busy is high is dropped. It changes neither the running transaction nor its result, and it does not start a later transaction.
- R11: mdi has no effect outside the capture edges of the sampling periods.
- R12: While idle, mdc and mdo_oe are low.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | System clock |
| rst | input | 1 | Synchronous active-high reset |
| req_valid | input | 1 | Request strobe, taken only while idle |
| req_read | input | 1 | 1 selects a read, 0 a write |
| req_phy | input | 5 | PHY address |
| req_reg | input | 5 | Register number inside the PHY |
| req_wdata | input | 16 | Value to write |
| busy | output | 1 | Transaction in progress |
| done | output | 1 | One-cycle completion pulse |
| rdata | output | 16 | Read result, or the written value for a write |
| mdc | output | 1 | Management clock |
| mdo | output | 1 | Value driven onto the data line |
| mdo_oe | output | 1 | Data line drive enable |
| mdi | input | 1 | Value sampled from the data line |

## Verification
The completion pulse and the acceptance of the next request can fall in the same cycle. The bench provokes this by presenting a new request exactly in the done cycle, from a write into a read and from a read into a write. It then expects the next preamble to start one cycle later, with no idle gap and with the finished result still shown on rdata. In the other direction, a request held for several cycles in the middle of a frame must leave the waveform untouched, and no new transaction may start after done. A cycle-by-cycle model in the bench judges both cases by comparing mdc, mdo, mdo_oe, busy, done and rdata on every clock.

// File: rtl/mfm_pkg.sv
package mfm_pkg;

    localparam int FRAME_W    = 32;
    localparam int DATA_W     = 16;
    localparam int ADDR_W     = 5;
    localparam int RD_DRIVEN  = 14;
    localparam int SAMPLE_N   = 16;

    typedef enum logic [2:0] {
        ST_IDLE,
        ST_PRE,
        ST_FRAME,
        ST_TURN,
        ST_SAMPLE,
        ST_POST
    } seq_st_e;

    typedef enum logic [1:0] {
        OP_WR = 2'b01,
        OP_RD = 2'b10
    } op_e;

    typedef struct packed {
        logic              rd;
        logic [ADDR_W-1:0] phy;
        logic [ADDR_W-1:0] regno;
        logic [DATA_W-1:0] wdata;
    } mgmt_req_t;

    function automatic logic [FRAME_W-1:0] pack_frame(input mgmt_req_t r);
        op_e op;
        op = r.rd ? OP_RD : OP_WR;
        return {2'b01, op, r.phy, r.regno, 2'b10, r.wdata};
    endfunction

endpackage

// File: rtl/mfm_halfclk.sv
module mfm_halfclk #(
    parameter int HALF_DIV = 125
) (
    input  logic clk,
    input  logic rst,
    input  logic run,
    output logic rise_evt,
    output logic bit_end,
    output logic mdc
);
    localparam int HC_W = (HALF_DIV > 1) ? $clog2(HALF_DIV) : 1;

    logic [HC_W-1:0] hcnt;
    logic            ph;
    logic            half_end;

    assign half_end = run && (hcnt == HC_W'(HALF_DIV - 1));
    assign rise_evt = half_end && !ph;
    assign bit_end  = half_end && ph;
    assign mdc      = ph;

    always_ff @(posedge clk) begin
        if (rst || !run) begin
            hcnt <= '0;
            ph   <= 1'b0;
        end else if (half_end) begin
            hcnt <= '0;
            ph   <= ~ph;
        end else begin
            hcnt <= hcnt + HC_W'(1);
        end
    end

endmodule

// File: rtl/mfm_seq.sv
module mfm_seq
    import mfm_pkg::*;
#(
    parameter int PAD_LEN = 32
) (
    input  logic              clk,
    input  logic              rst,
    input  logic              req_valid,
    input  mgmt_req_t         req_in,
    input  logic              rise_evt,
    input  logic              bit_end,
    output logic              busy,
    output logic              mdo,
    output logic              mdo_oe,
    output logic              done,
    output logic              sample_en,
    output logic              finish_evt,
    output logic              rd_q,
    output logic [DATA_W-1:0] wdata_q
);
    localparam int CNT_MAX = (PAD_LEN > FRAME_W) ? PAD_LEN : FRAME_W;
    localparam int CNT_W   = $clog2(CNT_MAX);

    seq_st_e            st;
    logic [CNT_W-1:0]   cnt;
    logic [CNT_W-1:0]   lim;
    logic [FRAME_W-1:0] txsh;
    logic               at_last;

    always_comb begin
        case (st)
            ST_PRE, ST_POST: lim = CNT_W'(PAD_LEN - 1);
            ST_FRAME:        lim = rd_q ? CNT_W'(RD_DRIVEN - 1) : CNT_W'(FRAME_W - 1);
            ST_SAMPLE:       lim = CNT_W'(SAMPLE_N - 1);
            default:         lim = '0;
        endcase
    end

    assign at_last    = (cnt == lim);
    assign busy       = (st != ST_IDLE);
    assign sample_en  = (st == ST_SAMPLE) && rise_evt;
    assign finish_evt = (st == ST_POST) && bit_end && at_last;

    always_ff @(posedge clk) begin
        if (rst) begin
            st      <= ST_IDLE;
            cnt     <= '0;
            txsh    <= '0;
            mdo     <= 1'b1;
            mdo_oe  <= 1'b0;
            done    <= 1'b0;
            rd_q    <= 1'b0;
            wdata_q <= '0;
        end else begin
            done <= 1'b0;
            if (st == ST_IDLE) begin
                if (req_valid) begin
                    st      <= ST_PRE;
                    cnt     <= '0;
                    txsh    <= pack_frame(req_in);
                    rd_q    <= req_in.rd;
                    wdata_q <= req_in.wdata;
                    mdo     <= 1'b1;
                    mdo_oe  <= 1'b1;
                end
            end else if (bit_end) begin
                if (!at_last) begin
                    cnt <= cnt + CNT_W'(1);
                    if (st == ST_FRAME) begin
                        mdo  <= txsh[FRAME_W-1];
                        txsh <= {txsh[FRAME_W-2:0], 1'b0};
                    end
                end else begin
                    cnt <= '0;
                    case (st)
                        ST_PRE: begin
                            st   <= ST_FRAME;
                            mdo  <= txsh[FRAME_W-1];
                            txsh <= {txsh[FRAME_W-2:0], 1'b0};
                        end
                        ST_FRAME: begin
                            mdo <= 1'b1;
                            if (rd_q) begin
                                st     <= ST_TURN;
                                mdo_oe <= 1'b0;
                            end else begin
                                st <= ST_POST;
                            end
                        end
                        ST_TURN: st <= ST_SAMPLE;
                        ST_SAMPLE: begin
                            st     <= ST_POST;
                            mdo    <= 1'b1;
                            mdo_oe <= 1'b1;
                        end
                        ST_POST: begin
                            st     <= ST_IDLE;
                            mdo_oe <= 1'b0;
                            done   <= 1'b1;
                        end
                        default: st <= ST_IDLE;
                    endcase
                end
            end
        end
    end

    // R9
    done_single_chk: assert property (@(posedge clk) disable iff (rst)
        done |=> !done);

    // R2
    done_ends_busy_chk: assert property (@(posedge clk) disable iff (rst)
        done |-> (!busy && $past(busy)));

endmodule

// File: rtl/mfm_capture.sv
module mfm_capture
    import mfm_pkg::*;
(
    input  logic              clk,
    input  logic              rst,
    input  logic              sample_en,
    input  logic              mdi,
    input  logic              finish_evt,
    input  logic              rd_q,
    input  logic [DATA_W-1:0] wdata_q,
    output logic [DATA_W-1:0] rdata
);
    logic [DATA_W-1:0] shreg;

    always_ff @(posedge clk) begin
        if (rst) begin
            shreg <= '0;
            rdata <= '0;
        end else begin
            if (sample_en) begin
                shreg <= {shreg[DATA_W-2:0], mdi};
            end
            if (finish_evt) begin
                rdata <= rd_q ? shreg : wdata_q;
            end
        end
    end

endmodule

// File: rtl/mgmt_frame_master.sv
module mgmt_frame_master
    import mfm_pkg::*;
#(
    parameter int HALF_DIV = 125,
    parameter int PAD_LEN  = 32
) (
    input  logic        clk,
    input  logic        rst,
    input  logic        req_valid,
    input  logic        req_read,
    input  logic [4:0]  req_phy,
    input  logic [4:0]  req_reg,
    input  logic [15:0] req_wdata,
    output logic        busy,
    output logic        done,
    output logic [15:0] rdata,
    output logic        mdc,
    output logic        mdo,
    output logic        mdo_oe,
    input  logic        mdi
);
    mgmt_req_t         req_in;
    logic              rise_evt;
    logic              bit_end;
    logic              sample_en;
    logic              finish_evt;
    logic              rd_q;
    logic [DATA_W-1:0] wdata_q;

    assign req_in = '{rd: req_read, phy: req_phy, regno: req_reg, wdata: req_wdata};

    mfm_halfclk #(.HALF_DIV(HALF_DIV)) u_halfclk (
        .clk      (clk),
        .rst      (rst),
        .run      (busy),
        .rise_evt (rise_evt),
        .bit_end  (bit_end),
        .mdc      (mdc)
    );

    mfm_seq #(.PAD_LEN(PAD_LEN)) u_seq (
        .clk        (clk),
        .rst        (rst),
        .req_valid  (req_valid),
        .req_in     (req_in),
        .rise_evt   (rise_evt),
        .bit_end    (bit_end),
        .busy       (busy),
        .mdo        (mdo),
        .mdo_oe     (mdo_oe),
        .done       (done),
        .sample_en  (sample_en),
        .finish_evt (finish_evt),
        .rd_q       (rd_q),
        .wdata_q    (wdata_q)
    );

    mfm_capture u_capture (
        .clk        (clk),
        .rst        (rst),
        .sample_en  (sample_en),
        .mdi        (mdi),
        .finish_evt (finish_evt),
        .rd_q       (rd_q),
        .wdata_q    (wdata_q),
        .rdata      (rdata)
    );

    // R5
    mdo_moves_low_chk: assert property (@(posedge clk) disable iff (rst)
        (mdo_oe && $past(mdo_oe) && !$stable(mdo)) |-> !mdc);

    // R12
    idle_quiet_chk: assert property (@(posedge clk) disable iff (rst)
        !busy |-> (!mdc && !mdo_oe));

    // R7
    capture_at_rise_chk: assert property (@(posedge clk) disable iff (rst)
        sample_en |=> (mdc && !mdo_oe));

endmodule

// File: tb/tb_mgmt_frame_master.sv
`timescale 1ns/1ps
module tb_mgmt_frame_master;
    localparam int H   = 3;
    localparam int PAD = 32;

    logic        clk = 1'b0;
    logic        rst;
    logic        req_valid, req_read;
    logic [4:0]  req_phy, req_reg;
    logic [15:0] req_wdata;
    logic        busy, done, mdc, mdo, mdo_oe, mdi;
    logic [15:0] rdata;

    int n_chk  = 0;
    int n_fail = 0;

    always #4 clk = ~clk;

    mgmt_frame_master #(.HALF_DIV(H), .PAD_LEN(PAD)) dut (
        .clk(clk), .rst(rst), .req_valid(req_valid), .req_read(req_read),
        .req_phy(req_phy), .req_reg(req_reg), .req_wdata(req_wdata),
        .busy(busy), .done(done), .rdata(rdata), .mdc(mdc), .mdo(mdo),
        .mdo_oe(mdo_oe), .mdi(mdi)
    );

    task automatic chk(input string tag, input string what,
                       input logic [31:0] act, input logic [31:0] exp);
        n_chk++;
        if (act !== exp) begin
            n_fail++;
            $display("FAIL %s %s: actual %0h expected %0h at %0t", tag, what, act, exp, $time);
        end
    endtask

    task automatic drive_req(input bit rd, input logic [4:0] phy, input logic [4:0] rg,
                             input logic [15:0] wd);
        req_valid = 1'b1;
        req_read  = rd;
        req_phy   = phy;
        req_reg   = rg;
        req_wdata = wd;
    endtask

    task automatic idle_chk(input int n);
        for (int i = 0; i < n; i++) begin
            @(negedge clk);
            chk("R12", "mdc idle", mdc, 0);
            chk("R12", "oe idle", mdo_oe, 0);
            chk("R10", "busy idle", busy, 0);
            chk("R12", "done idle", done, 0);
        end
    endtask

    // Behavioural per-cycle model of one transaction; request already driven.
    task automatic run_txn(input bit rd, input logic [4:0] phy, input logic [4:0] rg,
                           input logic [15:0] wd, input logic [15:0] pdata,
                           input bit intr, input bit chain,
                           input bit nrd, input logic [4:0] nphy, input logic [4:0] nrg,
                           input logic [15:0] nwd);
        int L, N, T, k, smp0;
        bit hi, e_oe, e_mdo;
        string tag;
        logic [31:0] fr;
        logic [15:0] e_rd;
        L    = rd ? 14 : 32;
        N    = rd ? (2 * PAD + 14 + 1 + 16) : (2 * PAD + 32);
        T    = N * 2 * H;
        smp0 = PAD + 15;
        fr   = {2'b01, (rd ? 2'b10 : 2'b01), phy, rg, 2'b10, wd};
        e_rd = rd ? pdata : wd;
        @(posedge clk);
        for (int c = 0; c <= T; c++) begin
            @(negedge clk);
            if (c == 0) req_valid = 1'b0;
            k  = c / (2 * H);
            hi = (c % (2 * H)) >= H;
            e_mdo = 1'b1;
            if (c == T) begin
                e_oe = 1'b0; tag = "R9";
            end else if (k < PAD) begin
                e_oe = 1'b1; tag = "R3";
            end else if (k < PAD + L) begin
                e_oe = 1'b1; e_mdo = fr[31 - (k - PAD)]; tag = rd ? "R4" : "R6";
            end else if (rd && k < smp0 + 16) begin
                e_oe = 1'b0; tag = "R7";
            end else begin
                e_oe = 1'b1; tag = "R8";
            end
            if (intr) tag = "R10";
            chk("R2", "busy", busy, (c < T) ? 1 : 0);
            chk(tag, "done", done, (c == T) ? 1 : 0);
            chk(tag, "mdc", mdc, (c < T && hi) ? 1 : 0);
            chk(tag, "mdo_oe", mdo_oe, e_oe);
            if (e_oe) chk((hi && !intr) ? "R5" : tag, "mdo", mdo, e_mdo);
            if (c == T) begin
                chk(tag, "rdata", rdata, e_rd);
                if (rd) chk("R11", "rdata with line noise", rdata, e_rd);
            end
            // PHY model: data during sampling periods, noise elsewhere
            if (rd && k >= smp0 && k < smp0 + 16) mdi = pdata[15 - (k - smp0)];
            else mdi = ((c / 2) % 2) == 1;
            if (intr && c >= 100 && c < 106) drive_req(~rd, 5'h15, 5'h0A, 16'hDEAD);
            if (intr && c == 106) req_valid = 1'b0;
            if (c == T) begin
                if (chain) drive_req(nrd, nphy, nrg, nwd);
                else req_valid = 1'b0;
            end
        end
    endtask

    initial begin
        repeat (150000) @(posedge clk);
        n_fail++;
        $display("FAIL watchdog: actual timeout expected completion");
        $display("  [TB] %0d tests run, %0d failed", n_chk, n_fail);
        $finish;
    end

    initial begin
        rst = 1'b1; req_valid = 1'b0; req_read = 1'b0;
        req_phy = '0; req_reg = '0; req_wdata = '0; mdi = 1'b0;
        repeat (3) @(negedge clk);
        chk("R1", "busy in reset", busy, 0);
        chk("R1", "oe in reset", mdo_oe, 0);
        rst = 1'b0;
        @(negedge clk);
        chk("R1", "busy", busy, 0);
        chk("R1", "done", done, 0);
        chk("R1", "mdc", mdc, 0);
        chk("R1", "mdo_oe", mdo_oe, 0);
        chk("R1", "mdo", mdo, 1);
        chk("R1", "rdata", rdata, 0);
        idle_chk(3);
        // write chained into a read in the done cycle
        drive_req(1'b0, 5'h01, 5'h00, 16'h8000);
        run_txn(1'b0, 5'h01, 5'h00, 16'h8000, 16'h0, 1'b0, 1'b1, 1'b1, 5'h1F, 5'h01, 16'h1234);
        run_txn(1'b1, 5'h1F, 5'h01, 16'h1234, 16'hA5C3, 1'b0, 1'b0, 1'b0, 5'h0, 5'h0, 16'h0);
        idle_chk(4);
        // write with a request arriving mid-frame
        @(negedge clk);
        drive_req(1'b0, 5'h0A, 5'h15, 16'h3C5A);
        run_txn(1'b0, 5'h0A, 5'h15, 16'h3C5A, 16'h0, 1'b1, 1'b0, 1'b0, 5'h0, 5'h0, 16'h0);
        idle_chk(20);
        // read boundary patterns
        @(negedge clk);
        drive_req(1'b1, 5'h00, 5'h1F, 16'h0);
        run_txn(1'b1, 5'h00, 5'h1F, 16'h0, 16'h0001, 1'b0, 1'b0, 1'b0, 5'h0, 5'h0, 16'h0);
        idle_chk(2);
        @(negedge clk);
        drive_req(1'b1, 5'h03, 5'h02, 16'h0);
        run_txn(1'b1, 5'h03, 5'h02, 16'h0, 16'hFFFE, 1'b0, 1'b1, 1'b0, 5'h1F, 5'h1F, 16'hFFFF);
        run_txn(1'b0, 5'h1F, 5'h1F, 16'hFFFF, 16'h0, 1'b0, 1'b0, 1'b0, 5'h0, 5'h0, 16'h0);
        idle_chk(3);
        $display("  [TB] %0d tests run, %0d failed", n_chk, n_fail);
        $finish;
    end

endmodule